// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Trap Control

This unit keeps the 16-bit program counter and a one-bit privilege flag for a small 16-bit processor. Each instruction word is decoded combinationally to find the address of the next instruction. The PC register loads that address on a rising clock edge while the advance strobe is high. With the strobe low, the PC and the privilege flag hold their values.

The control-flow group is:
- relative jumps and calls with a 12-bit signed displacement;
- register-indirect jumps and calls;
- a trap to an 8-bit vector, which raises the privilege flag;
- a return from trap, which lowers it;
- a conditional branch. Its 3-bit mask selects any mix of negative, zero and positive, and the mask is tested against the signed value of a register.

The surrounding register file reads the register named by bits 11:9 and presents its value on `rd_val`. Calls and traps raise a link-write request in the same cycle. The request carries PC+1 and targets register 7. Every other opcode simply moves the PC forward by one.

Top module: `flow_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0x0000 and clears the privilege flag.
- R2: While `adv` is low, the PC and the privilege flag keep their values at every clock edge, and `link_we` stays low.
- R3: Any opcode (bits 15:12) other than 0010, 0011, 0100, 0101, 0110, 0111 and 1000 sets the PC to PC+1. It leaves the privilege flag unchanged and requests no link write.
- R4: Opcode 0100 sets the PC to PC+1 plus bits 11:0 taken as a two's-complement 12-bit value.
- R5: Opcode 0110 computes the same target as opcode 0100 and also requests a link write.
- R6: Opcode 0101 loads the PC from `rd_val`. Opcode 0111 does the same and also requests a link write.
- R7: Opcode 0010 loads the PC with bits 7:0 zero-extended, sets the privilege flag to 1 and requests a link write.
- R8: Opcode 0011 loads the PC from `rd_val` and clears the privilege flag.
- R9: For opcode 1000, bit 8 enables negative, bit 7 enables zero and bit 6 enables positive. If any enabled condition holds for the signed `rd_val`, the PC becomes PC+1 plus bits 5:0 sign-extended. Otherwise the PC becomes PC+1. Mask 000 never branches and mask 111 always branches.
- R10: A link request drives `link_we` high in the same cycle as the instruction, with `link_idx` = 7 and `link_data` = current PC+1.
- R11: All PC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Advance strobe: the current instruction retires on this edge |
| instr | input | 16 | Instruction word at the current PC |
| rd_val | input | 16 | Value of the register named by instr[11:9] |
| pc_o | output | 16 | Current program counter |
| priv_o | output | 1 | Privilege flag |
| link_we | output | 1 | Link-register write request |
| link_idx | output | 3 | Register index of the link write (always 7) |
| link_data | output | 16 | Return address PC+1 |

## Verification
The branch sweep runs all eight masks against the register values zero, one, the largest positive value, the most negative value and minus one. A design that treated zero as positive, or read the sign from the wrong bit, would take or skip the wrong branches there. Displacements sit at their extremes (0x7FF, 0x800, 31, -32), and the PC bases are placed just below 0xFFFF. This catches a sign-extension slip, or arithmetic wider than 16 bits that fails to wrap. All 256 trap vectors are tried to catch sign-extension of the vector or a missed privilege update. Calls issued with the strobe low expose a link request or PC move that ignores the strobe.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int XLEN      = 16;
    localparam int OPC_W     = 4;
    localparam int RIDX_W    = 3;
    localparam int OFF_L_W   = 12;
    localparam int OFF_S_W   = 6;
    localparam int VEC_W     = 8;
    localparam int MASK_W    = 3;
    localparam int MASK_LSB  = 6;

    localparam logic [OPC_W-1:0] OPC_TRAP  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_RTT   = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_JREL  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_JREG  = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_CREL  = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_CREG  = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_BCND  = 4'b1000;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        K_SEQ,
        K_REL,
        K_REG,
        K_TRAP,
        K_RTT,
        K_BR
    } flow_kind_e;

    typedef enum logic [1:0] {
        PRIV_KEEP,
        PRIV_SET,
        PRIV_CLR
    } priv_op_e;

    typedef struct packed {
        flow_kind_e          kind;
        logic                link;
        logic [OFF_L_W-1:0]  off_long;
        logic [OFF_S_W-1:0]  off_short;
        logic [VEC_W-1:0]    vector;
        logic [MASK_W-1:0]   mask;
    } flow_dec_t;

    function automatic word_t sext_field(input word_t raw, input int nbits);
        word_t r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < nbits) ? raw[i] : raw[nbits-1];
        end
        return r;
    endfunction

    function automatic word_t zext_field(input word_t raw, input int nbits);
        word_t r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < nbits) ? raw[i] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
(
    input  word_t     instr,
    output flow_dec_t dec
);
    logic [OPC_W-1:0] opc;

    assign opc = instr[XLEN-1 -: OPC_W];

    always_comb begin
        dec.kind      = K_SEQ;
        dec.link      = 1'b0;
        dec.off_long  = instr[OFF_L_W-1:0];
        dec.off_short = instr[OFF_S_W-1:0];
        dec.vector    = instr[VEC_W-1:0];
        dec.mask      = instr[MASK_LSB +: MASK_W];
        unique case (opc)
            OPC_JREL: dec.kind = K_REL;
            OPC_CREL: begin dec.kind = K_REL;  dec.link = 1'b1; end
            OPC_JREG: dec.kind = K_REG;
            OPC_CREG: begin dec.kind = K_REG;  dec.link = 1'b1; end
            OPC_TRAP: begin dec.kind = K_TRAP; dec.link = 1'b1; end
            OPC_RTT:  dec.kind = K_RTT;
            OPC_BCND: dec.kind = K_BR;
            default:  dec.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
(
    input  word_t             value,
    input  logic [MASK_W-1:0] mask,
    output logic              taken
);
    logic is_neg, is_zero, is_pos;
    logic [MASK_W-1:0] status;

    always_comb begin
        is_neg  = value[XLEN-1];
        is_zero = ~|value;
        is_pos  = ~is_neg & ~is_zero;
        status  = {is_neg, is_zero, is_pos};
        taken   = |(mask & status);
    end
endmodule

// File: rtl/flow_target.sv
module flow_target
    import flow_pkg::*;
(
    input  word_t     pc,
    input  word_t     rd_val,
    input  flow_dec_t dec,
    input  logic      taken,
    output word_t     pc_inc,
    output word_t     next_pc,
    output priv_op_e  priv_op
);
    word_t disp_long;
    word_t disp_short;
    word_t vec_addr;

    always_comb begin
        pc_inc     = pc + word_t'(1);
        disp_long  = sext_field(word_t'(dec.off_long),  OFF_L_W);
        disp_short = sext_field(word_t'(dec.off_short), OFF_S_W);
        vec_addr   = zext_field(word_t'(dec.vector),    VEC_W);
        priv_op    = PRIV_KEEP;
        next_pc    = pc_inc;
        unique case (dec.kind)
            K_REL:  next_pc = pc_inc + disp_long;
            K_REG:  next_pc = rd_val;
            K_TRAP: begin next_pc = vec_addr; priv_op = PRIV_SET; end
            K_RTT:  begin next_pc = rd_val;   priv_op = PRIV_CLR; end
            K_BR:   next_pc = taken ? (pc_inc + disp_short) : pc_inc;
            default: next_pc = pc_inc;
        endcase
    end
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
    import flow_pkg::*;
#(
    parameter int          LINK_REG = 7,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [15:0]       instr,
    input  logic [15:0]       rd_val,
    output logic [15:0]       pc_o,
    output logic              priv_o,
    output logic              link_we,
    output logic [2:0]        link_idx,
    output logic [15:0]       link_data
);
    flow_dec_t dec;
    logic      taken;
    word_t     pc_q, pc_inc, next_pc;
    logic      priv_q;
    priv_op_e  priv_op;

    flow_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    flow_cond u_cond (
        .value (rd_val),
        .mask  (dec.mask),
        .taken (taken)
    );

    flow_target u_tgt (
        .pc      (pc_q),
        .rd_val  (rd_val),
        .dec     (dec),
        .taken   (taken),
        .pc_inc  (pc_inc),
        .next_pc (next_pc),
        .priv_op (priv_op)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_PC;
            priv_q <= 1'b0;
        end else if (adv) begin
            pc_q <= next_pc;
            case (priv_op)
                PRIV_SET: priv_q <= 1'b1;
                PRIV_CLR: priv_q <= 1'b0;
                default:  priv_q <= priv_q;
            endcase
        end
    end

    assign pc_o      = pc_q;
    assign priv_o    = priv_q;
    assign link_we   = adv & dec.link;
    assign link_idx  = RIDX_W'(LINK_REG);
    assign link_data = pc_inc;

    // R2: no retirement without the strobe
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(pc_q) && $stable(priv_q)));

    // R3: plain opcodes step by one
    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && dec.kind == K_SEQ) |=> (pc_q == word_t'($past(pc_q) + 1'b1)));

    // R7: trap lands on the vector with privilege raised
    p_trap_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && dec.kind == K_TRAP) |=> (priv_q && pc_q == {8'h00, $past(instr[7:0])}));

    // R8: return drops privilege and jumps to the register
    p_rtt_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && dec.kind == K_RTT) |=> (!priv_q && pc_q == $past(rd_val)));

    // R9: empty mask never branches
    p_br_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && dec.kind == K_BR && dec.mask == '0) |=> (pc_q == word_t'($past(pc_q) + 1'b1)));

    // R10: link request never appears without the strobe
    p_link_gate_r10: assert property (@(posedge clk) disable iff (rst)
        link_we |-> adv);
endmodule

// File: tb/sim_flow_ctrl.sv
module sim_flow_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [15:0] rd_val = 16'h0000;
    logic [15:0] pc_o, link_data;
    logic        priv_o, link_we;
    logic [2:0]  link_idx;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_pc = 16'h0000;
    logic        exp_priv = 1'b0;

    always #5 clk = ~clk;

    flow_ctrl u0 (
        .clk(clk), .rst(rst), .adv(adv), .instr(instr), .rd_val(rd_val),
        .pc_o(pc_o), .priv_o(priv_o), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [15:0] ins);
        case (ins[15:12])
            4'b0100: return "R4/R11";
            4'b0110: return "R5/R11";
            4'b0101, 4'b0111: return "R6";
            4'b0010: return "R7";
            4'b0011: return "R8";
            4'b1000: return "R9/R11";
            default: return "R3";
        endcase
    endfunction

    task automatic step(input logic [15:0] ins, input logic [15:0] rv, input bit go);
        logic [3:0]  op;
        logic        lk, neg, zer, pos, tk;
        logic [15:0] nxt, inc;
        string       tg;
        op = ins[15:12];
        tg = go ? tag_of(ins) : "R2";
        @(negedge clk);
        instr = ins; rd_val = rv; adv = go;
        #1;
        inc = exp_pc + 16'd1;
        lk  = go && (op == 4'b0110 || op == 4'b0111 || op == 4'b0010);
        chk(link_we == lk, {tg, " R10 link_we"}, {15'd0, link_we}, {15'd0, lk});
        if (lk) begin
            chk(link_idx == 3'd7, "R10 link_idx", {13'd0, link_idx}, 16'd7);
            chk(link_data == inc, "R10 link_data", link_data, inc);
        end
        neg = rv[15]; zer = (rv == 16'd0); pos = !neg && !zer;
        tk  = (ins[8] && neg) || (ins[7] && zer) || (ins[6] && pos);
        case (op)
            4'b0100, 4'b0110: nxt = inc + {{4{ins[11]}}, ins[11:0]};
            4'b0101, 4'b0111: nxt = rv;
            4'b0010: nxt = {8'h00, ins[7:0]};
            4'b0011: nxt = rv;
            4'b1000: nxt = tk ? inc + {{10{ins[5]}}, ins[5:0]} : inc;
            default: nxt = inc;
        endcase
        if (go) begin
            exp_pc = nxt;
            if (op == 4'b0010) exp_priv = 1'b1;
            if (op == 4'b0011) exp_priv = 1'b0;
        end
        @(posedge clk);
        #1;
        chk(pc_o == exp_pc, {tg, " pc"}, pc_o, exp_pc);
        chk(priv_o == exp_priv, {tg, " priv"}, {15'd0, priv_o}, {15'd0, exp_priv});
    endtask

    task automatic set_pc(input logic [15:0] v);
        step({4'b0101, 12'h000}, v, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; adv = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_pc = 16'h0000; exp_priv = 1'b0;
        #1;
        chk(pc_o == 16'h0000, "R1 pc after reset", pc_o, 16'h0000);
        chk(priv_o == 1'b0, "R1 priv after reset", {15'd0, priv_o}, 16'd0);
        chk(link_we == 1'b0, "R1 link idle", {15'd0, link_we}, 16'd0);
    endtask

    initial begin
        automatic logic [3:0]  plain_ops[9] = '{4'h0, 4'h1, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
        automatic logic [15:0] bases[4]     = '{16'h0000, 16'h1234, 16'hFFF8, 16'h8000};
        automatic logic [11:0] offs[6]      = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h123};
        automatic logic [15:0] rvals[6]     = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0005};
        automatic logic [5:0]  soffs[4]     = '{6'h00, 6'h1F, 6'h20, 6'h3F};
        automatic logic [15:0] bbase[2]     = '{16'h4000, 16'hFFE0};

        do_reset();

        // R2: strobe low holds everything, even for calls and traps
        step({4'b0100, 12'h005}, 16'h0000, 1'b0);
        step({4'b0110, 12'h010}, 16'h0000, 1'b0);
        step({4'b0010, 12'h0AB}, 16'h0000, 1'b0);
        set_pc(16'h0300);
        step({4'b0111, 12'h000}, 16'h9999, 1'b0);

        // R3: non-flow opcodes
        foreach (plain_ops[i]) begin
            step({plain_ops[i], 12'hFFF}, 16'h8000, 1'b1);
            step({plain_ops[i], 12'h000}, 16'h0000, 1'b1);
        end
        set_pc(16'hFFFF);
        step(16'h0000, 16'h0000, 1'b1); // R11 wrap to zero

        // R4, R5, R11: relative jumps and calls
        foreach (bases[b]) begin
            foreach (offs[o]) begin
                set_pc(bases[b]);
                step({4'b0100, offs[o]}, 16'h0000, 1'b1);
                set_pc(bases[b]);
                step({4'b0110, offs[o]}, 16'h0000, 1'b1);
            end
        end

        // R6: register jumps and calls
        foreach (rvals[r]) begin
            step({4'b0101, 12'hE00}, rvals[r], 1'b1);
            step({4'b0111, 12'h200}, rvals[r] ^ 16'h5A5A, 1'b1);
        end

        // R7, R8: every trap vector, each followed by a return
        for (int v = 0; v < 256; v++) begin
            set_pc(16'hFF00 + 16'(v));
            step({4'b0010, 4'hF, 8'(v)}, 16'hFFFF, 1'b1);
            step({4'b0011, 12'h000}, 16'(v * 7), 1'b1);
        end
        step({4'b0011, 12'h000}, 16'h0042, 1'b1); // R8 with privilege already low

        // R9, R11: full mask x sign sweep
        for (int m = 0; m < 8; m++) begin
            foreach (rvals[r]) begin
                foreach (soffs[s]) begin
                    foreach (bbase[b]) begin
                        set_pc(bbase[b]);
                        step({4'b1000, 3'b101, 3'(m), soffs[s]}, rvals[r], 1'b1);
                    end
                end
            end
        end

        // R1: reset clears a raised privilege flag
        step({4'b0010, 12'h0C0}, 16'h0000, 1'b1);
        do_reset();

        @(negedge clk);
        adv = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%h expected=%h", 16'd1, 16'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule